// File: doc/BRIEF.md
# Host-to-ISA I/O Bridge with Stretched Strobes

This block connects a simple byte-wide host access port to an 8-bit ISA I/O target at a fixed base address. The host marks each access with a one-cycle select pulse, a direction bit, address line A1 and a data byte. A write with A1 low is a command access. It loads a byte whose top three bits name a target device and whose low five bits pick a register inside the ISA window. Accesses with A1 high are data accesses. They reach the ISA side only when the latched device field equals the `dev_id` strap.

Two timing schemes are selected by `mode_slow`. In fast mode the ISA read and write strobes follow the host access combinationally, for the single cycle of that access. In slow mode a small sequencer stretches each ISA cycle across two host accesses. The first access opens the cycle and the second closes it. Writes get one cycle of data setup before the strobe and one cycle of hold after it. A read or write that collides with an open cycle of the other kind is dropped and raises a sticky error flag.

Top module: `hib_bridge`

## Requirements
- R1: While `rst_n` is low, both ISA strobes are high, `isa_data_oe` is 0, `proto_err` is 0 and the command byte is 0, so `isa_addr` reads 0x300.
- R2: A host write with A1 low loads `host_wdata` as the command byte, and `isa_addr` becomes {0x300 upper five bits, command bits [4:0]}, i.e. 0x300 | cmd[4:0]. A host read with A1 low returns the command byte on `host_rdata` during that access.
- R3: A data access (A1 high) whose command bits [7:5] differ from `dev_id` changes no output and no state.
- R4: Any A1-low access returns the slow sequencer to idle, which releases both strobes from the next cycle.
- R5: In slow mode, a matching write from idle captures the data and drives it with `isa_data_oe` high and `isa_iow_n` high for one cycle. `isa_iow_n` is then low until the next matching write. After that write follows one hold cycle with the data still driven and `isa_iow_n` high, and then the sequencer is idle.
- R6: In slow mode, a matching read from idle pulls `isa_ior_n` low from the next cycle. The next matching read captures `isa_data_in`, releases `isa_ior_n`, and presents the captured byte on `host_rdata` from the following cycle.
- R7: In fast mode, with the sequencer idle, a matching write drives `isa_iow_n` low, `isa_data_oe` high and `isa_data_out` = `host_wdata` in the cycle of the access. A matching read drives `isa_ior_n` low and `host_rdata` = `isa_data_in` in that same cycle.
- R8: In fast mode the sequencer is forced to idle at every clock edge. A fast data access made while it has not yet reached idle produces no strobe.
- R9: In slow mode, a matching read while a write is open (setup, active or hold), a matching write while a read is open, or any matching access during a setup or hold cycle is ignored and sets `proto_err`. `proto_err` stays set until reset.
- R10: `isa_reset` is the inverse of `rst_n`.
- R11: `isa_ior_n` and `isa_iow_n` are never low together, and `isa_iow_n` low implies `isa_data_oe` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_slow | input | 1 | 1 = stretched two-access ISA cycles, 0 = direct strobes |
| dev_id | input | 3 | Device number this bridge answers to |
| host_sel | input | 1 | One-cycle access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_a1 | input | 1 | 0 = command access, 1 = data access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| isa_addr | output | 10 | ISA I/O address |
| isa_data_out | output | 8 | ISA write data |
| isa_data_oe | output | 1 | ISA data drive enable |
| isa_data_in | input | 8 | ISA read data |
| isa_ior_n | output | 1 | ISA read strobe, active low |
| isa_iow_n | output | 1 | ISA write strobe, active low |
| isa_reset | output | 1 | ISA reset, active high |
| proto_err | output | 1 | Sticky collision flag |

## Verification
The bench aims at accesses that land in the one-cycle setup and hold windows, at back-to-back command writes that cut a stretched write short, and at reads and writes that cross an open cycle of the other kind. If a design dropped the setup cycle, the strobe would fall together with the data. If it missed the clear, the strobe would stay low after a command. If it honoured a crossing access, both strobes could go low at once or the error flag would stay clear. Device-field mismatches and mode switches during an open slow cycle are mixed into seeded random traffic. These catch a compare on the wrong bits, or a fast strobe that fires while the sequencer still holds a cycle open.

// File: rtl/hib_pkg.sv
package hib_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_WSETUP = 3'd1,
    SQ_WACT   = 3'd2,
    SQ_WHOLD  = 3'd3,
    SQ_RACT   = 3'd4
  } seq_t;
endpackage

// File: rtl/hib_cmd_reg.sv
module hib_cmd_reg #(
  parameter int DW   = 8,
  parameter int ID_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     cmd_q,
  output logic [ID_W-1:0]   id_q,
  output logic [DW-ID_W-1:0] reg_q
);
  localparam int LO_W = DW - ID_W;

  logic [DW-1:0] cmd_d;

  always_comb begin
    cmd_d = cmd_q;
    if (load) cmd_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else if (load) cmd_q <= cmd_d;
  end

  assign id_q  = cmd_q[DW-1:LO_W];
  assign reg_q = cmd_q[LO_W-1:0];
endmodule

// File: rtl/hib_slow_seq.sv
module hib_slow_seq
  import hib_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_hit,
  input  logic          rd_hit,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rdin,
  output seq_t          st_q,
  output logic [DW-1:0] wq_q,
  output logic [DW-1:0] rq_q,
  output logic          err_q
);
  seq_t          st_d;
  logic          err_d;
  logic          wq_en;
  logic          rq_en;

  always_comb begin
    st_d  = st_q;
    err_d = err_q;
    wq_en = 1'b0;
    rq_en = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (wr_hit) begin
          st_d  = SQ_WSETUP;
          wq_en = 1'b1;
        end else if (rd_hit) begin
          st_d = SQ_RACT;
        end
      end
      SQ_WSETUP: begin
        st_d = SQ_WACT;
        if (wr_hit || rd_hit) err_d = 1'b1;
      end
      SQ_WACT: begin
        if (wr_hit) st_d = SQ_WHOLD;
        else if (rd_hit) err_d = 1'b1;
      end
      SQ_WHOLD: begin
        st_d = SQ_IDLE;
        if (wr_hit || rd_hit) err_d = 1'b1;
      end
      SQ_RACT: begin
        if (rd_hit) begin
          st_d  = SQ_IDLE;
          rq_en = 1'b1;
        end else if (wr_hit) begin
          err_d = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
    if (clr) st_d = SQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wq_q <= '0;
    else if (wq_en) wq_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rq_q <= '0;
    else if (rq_en) rq_q <= rdin;
  end
endmodule

// File: rtl/hib_bridge.sv
module hib_bridge
  import hib_pkg::*;
#(
  parameter int          DW     = 8,
  parameter int          ID_W   = 3,
  parameter int          ADDR_W = 10,
  parameter logic [9:0]  BASE   = 10'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_slow,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_a1,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic [ADDR_W-1:0] isa_addr,
  output logic [DW-1:0]     isa_data_out,
  output logic              isa_data_oe,
  input  logic [DW-1:0]     isa_data_in,
  output logic              isa_ior_n,
  output logic              isa_iow_n,
  output logic              isa_reset,
  output logic              proto_err
);
  localparam int LO_W = DW - ID_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [DW-1:0]     cmd_q;
  logic [ID_W-1:0]   id_q;
  logic [LO_W-1:0]   reg_q;
  logic              acc_cmd;
  logic              acc_data;
  logic              slow_wr_hit;
  logic              slow_rd_hit;
  logic              fast_ok;
  logic              fast_wr;
  logic              fast_rd;
  logic              seq_clr;
  seq_t              seq_st;
  logic [DW-1:0]     seq_wq;
  logic [DW-1:0]     seq_rq;
  logic              w_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign acc_cmd  = host_sel && !host_a1;
  assign acc_data = host_sel && host_a1 && (id_q == dev_id);

  assign slow_wr_hit = acc_data && mode_slow && host_wr;
  assign slow_rd_hit = acc_data && mode_slow && !host_wr;
  assign fast_ok     = acc_data && !mode_slow && (seq_st == SQ_IDLE);
  assign fast_wr     = fast_ok && host_wr;
  assign fast_rd     = fast_ok && !host_wr;
  assign seq_clr     = acc_cmd || !mode_slow;

  hib_cmd_reg #(.DW(DW), .ID_W(ID_W)) u_cmd (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (acc_cmd && host_wr),
    .din   (host_wdata),
    .cmd_q (cmd_q),
    .id_q  (id_q),
    .reg_q (reg_q)
  );

  hib_slow_seq #(.DW(DW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (seq_clr),
    .wr_hit (slow_wr_hit),
    .rd_hit (slow_rd_hit),
    .wdata  (host_wdata),
    .rdin   (isa_data_in),
    .st_q   (seq_st),
    .wq_q   (seq_wq),
    .rq_q   (seq_rq),
    .err_q  (proto_err)
  );

  generate
    if (ADDR_W > LO_W) begin : g_addr_base
      assign isa_addr = {BASE[ADDR_W-1:LO_W], reg_q};
    end else begin : g_addr_flat
      assign isa_addr = reg_q[ADDR_W-1:0];
    end
  endgenerate

  assign w_open = (seq_st == SQ_WSETUP) || (seq_st == SQ_WACT) || (seq_st == SQ_WHOLD);

  always_comb begin
    isa_iow_n    = !(fast_wr || (seq_st == SQ_WACT));
    isa_ior_n    = !(fast_rd || (seq_st == SQ_RACT));
    isa_data_oe  = fast_wr || w_open;
    isa_data_out = fast_wr ? host_wdata : seq_wq;
    if (fast_rd)                  host_rdata = isa_data_in;
    else if (acc_cmd && !host_wr) host_rdata = cmd_q;
    else                          host_rdata = seq_rq;
  end

  assign isa_reset = !rst_n;
endmodule

// File: rtl/hib_bridge_chk.sv
module hib_bridge_chk
  import hib_pkg::*;
#(
  parameter int         ADDR_W = 10,
  parameter int         LO_W   = 5,
  parameter logic [9:0] BASE   = 10'h300
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_a1,
  input logic              isa_iow_n,
  input logic              isa_ior_n,
  input logic              isa_data_oe,
  input logic [ADDR_W-1:0] isa_addr,
  input logic              proto_err,
  input seq_t              seq_st
);
  assert_excl_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!isa_iow_n && !isa_ior_n));

  assert_wr_drives_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !isa_iow_n |-> isa_data_oe);

  assert_cmd_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_a1) |=> (seq_st == SQ_IDLE));

  assert_base_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    isa_addr[ADDR_W-1:LO_W] == BASE[ADDR_W-1:LO_W]);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  assert_setup_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_st == SQ_WACT && $past(seq_st) != SQ_WACT) |-> ($past(seq_st) == SQ_WSETUP));
endmodule

bind hib_bridge hib_bridge_chk #(
  .ADDR_W (ADDR_W),
  .LO_W   (DW - ID_W),
  .BASE   (BASE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_sel    (host_sel),
  .host_a1     (host_a1),
  .isa_iow_n   (isa_iow_n),
  .isa_ior_n   (isa_ior_n),
  .isa_data_oe (isa_data_oe),
  .isa_addr    (isa_addr),
  .proto_err   (proto_err),
  .seq_st      (seq_st)
);

// File: tb/tb_hib_bridge.sv
`timescale 1ns/1ps
module tb_hib_bridge;
  localparam logic [2:0] MY_ID = 3'd5;
  localparam int M_IDLE = 0, M_WSET = 1, M_WACT = 2, M_WHOLD = 3, M_RACT = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_slow;
  logic [2:0] dev_id;
  logic       host_sel, host_wr, host_a1;
  logic [7:0] host_wdata, host_rdata;
  logic [9:0] isa_addr;
  logic [7:0] isa_data_out, isa_data_in;
  logic       isa_data_oe, isa_ior_n, isa_iow_n, isa_reset, proto_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int         m_st;
  logic [7:0] m_cmd, m_wq, m_rq;
  logic       m_err;

  always #5 clk = ~clk;

  hib_bridge dut (
    .clk(clk), .rst_n(rst_n), .mode_slow(mode_slow), .dev_id(dev_id),
    .host_sel(host_sel), .host_wr(host_wr), .host_a1(host_a1),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .isa_addr(isa_addr),
    .isa_data_out(isa_data_out), .isa_data_oe(isa_data_oe),
    .isa_data_in(isa_data_in), .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n),
    .isa_reset(isa_reset), .proto_err(proto_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] exp_addr(logic [7:0] c);
    return 10'h300 | {5'd0, c[4:0]};
  endfunction

  function automatic bit w_open(int s);
    return (s == M_WSET) || (s == M_WACT) || (s == M_WHOLD);
  endfunction

  // Outputs expected from model state when no access is in flight
  task automatic check_state(string tag);
    chk({tag, " R5 iow"}, isa_iow_n, !(m_st == M_WACT));
    chk({tag, " R6 ior"}, isa_ior_n, !(m_st == M_RACT));
    chk({tag, " R5 oe"}, isa_data_oe, w_open(m_st));
    if (w_open(m_st)) chk({tag, " R5 data"}, isa_data_out, m_wq);
    chk({tag, " R2 addr"}, isa_addr, exp_addr(m_cmd));
    chk({tag, " R9 err"}, proto_err, m_err);
    chk({tag, " R6 rdata"}, host_rdata, m_rq);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (!mode_slow) m_st = M_IDLE;
      else if (m_st == M_WSET) m_st = M_WACT;
      else if (m_st == M_WHOLD) m_st = M_IDLE;
      @(negedge clk); #1;
      check_state("idle");
    end
  endtask

  // Called after a negedge; drives one access for one cycle
  task automatic access(bit wr, bit a1, logic [7:0] d, logic [7:0] din);
    bit hit;
    host_sel = 1'b1; host_wr = wr; host_a1 = a1; host_wdata = d; isa_data_in = din;
    #1;
    hit = a1 && (m_cmd[7:5] == dev_id);
    if (!a1 && !wr) chk("R2 cmd readback", host_rdata, m_cmd);
    if (hit && !mode_slow && m_st == M_IDLE) begin
      if (wr) begin
        chk("R7 fast iow", isa_iow_n, 1'b0);
        chk("R7 fast oe", isa_data_oe, 1'b1);
        chk("R7 fast data", isa_data_out, d);
      end else begin
        chk("R7 fast ior", isa_ior_n, 1'b0);
        chk("R7 fast rdata", host_rdata, din);
      end
    end else if (hit && !mode_slow) begin
      chk("R8 gated iow", isa_iow_n, !(m_st == M_WACT));
      chk("R8 gated ior", isa_ior_n, !(m_st == M_RACT));
    end else if (a1 && !hit) begin
      chk("R3 mismatch iow", isa_iow_n, !(m_st == M_WACT));
      chk("R3 mismatch ior", isa_ior_n, !(m_st == M_RACT));
    end
    @(posedge clk);
    if (a1 && hit && mode_slow) begin
      case (m_st)
        M_IDLE:  if (wr) begin m_st = M_WSET; m_wq = d; end else m_st = M_RACT;
        M_WSET:  begin m_st = M_WACT; m_err = 1'b1; end
        M_WACT:  if (wr) m_st = M_WHOLD; else m_err = 1'b1;
        M_WHOLD: begin m_st = M_IDLE; m_err = 1'b1; end
        M_RACT:  if (!wr) begin m_st = M_IDLE; m_rq = din; end else m_err = 1'b1;
        default: m_st = M_IDLE;
      endcase
    end else if (mode_slow && a1) begin
      if (m_st == M_WSET) m_st = M_WACT;
      else if (m_st == M_WHOLD) m_st = M_IDLE;
    end
    if (!a1) begin
      if (wr) m_cmd = d;
      m_st = M_IDLE;
    end
    if (!mode_slow) m_st = M_IDLE;
    @(negedge clk);
    host_sel = 1'b0;
    #1;
    check_state("acc");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1A5E);
    rst_n = 1'b0; mode_slow = 1'b1; dev_id = MY_ID;
    host_sel = 1'b0; host_wr = 1'b0; host_a1 = 1'b0; host_wdata = 8'h00; isa_data_in = 8'h00;
    m_st = M_IDLE; m_cmd = 8'h00; m_wq = 8'h00; m_rq = 8'h00; m_err = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 iow", isa_iow_n, 1'b1);
    chk("R1 ior", isa_ior_n, 1'b1);
    chk("R1 oe", isa_data_oe, 1'b0);
    chk("R1 err", proto_err, 1'b0);
    chk("R1 addr", isa_addr, 10'h300);
    chk("R10 reset high", isa_reset, 1'b1);
    rst_n = 1'b1;
    #1;
    chk("R10 reset low", isa_reset, 1'b0);
    repeat (4) @(negedge clk);
    #1;

    // R2 command latch and readback
    access(1, 0, 8'hA7, 8'h00);
    chk("R2 addr 0x307", isa_addr, 10'h307);
    access(0, 0, 8'h00, 8'h00);

    // R5 stretched write
    access(1, 1, 8'h5C, 8'h00);
    chk("R5 setup iow high", isa_iow_n, 1'b1);
    idle(2);
    chk("R5 active iow low", isa_iow_n, 1'b0);
    access(1, 1, 8'h11, 8'h00);
    chk("R5 hold data", isa_data_out, 8'h5C);
    idle(1);
    chk("R5 back to idle", isa_data_oe, 1'b0);

    // R6 stretched read
    access(0, 1, 8'h00, 8'h99);
    idle(1);
    chk("R6 ior low", isa_ior_n, 1'b0);
    access(0, 1, 8'h00, 8'h3E);
    chk("R6 captured", host_rdata, 8'h3E);

    // R3 device mismatch
    access(1, 0, 8'h47, 8'h00);
    access(1, 1, 8'hEE, 8'h00);
    chk("R3 no write opened", isa_data_oe, 1'b0);
    idle(1);

    // R4 command cuts write short
    access(1, 0, 8'hA3, 8'h00);
    access(1, 1, 8'h77, 8'h00);
    idle(1);
    access(1, 0, 8'hA4, 8'h00);
    chk("R4 iow released", isa_iow_n, 1'b1);

    // R7 fast mode
    mode_slow = 1'b0;
    idle(1);
    access(1, 1, 8'hC3, 8'h00);
    access(0, 1, 8'h00, 8'h6D);
    idle(1);

    // R9 collision
    mode_slow = 1'b1;
    idle(1);
    access(0, 1, 8'h00, 8'h12);
    idle(1);
    access(1, 1, 8'h34, 8'h00);
    chk("R9 err set", proto_err, 1'b1);
    chk("R9 read still open", isa_ior_n, 1'b0);
    access(0, 1, 8'h00, 8'h56);
    chk("R9 err sticky", proto_err, 1'b1);

    // Seeded random traffic
    for (int it = 0; it < 600; it++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4) begin
        mode_slow = ~mode_slow;
        #1;
      end
      r = $urandom_range(0, 99);
      if (r < 20) begin
        logic [7:0] c;
        c = 8'($urandom);
        if ($urandom_range(0, 3) != 0) c[7:5] = MY_ID;
        access(1, 0, c, 8'h00);
      end else if (r < 25) begin
        access(0, 0, 8'h00, 8'($urandom));
      end else begin
        access(1'($urandom), 1, 8'($urandom), 8'($urandom));
      end
      if ($urandom_range(0, 9) != 0) idle($urandom_range(1, 3));
    end
    finish_run();
  end
endmodule